// File: doc/BRIEF.md
# Scatter-gather descriptor walker

This block sits between a storage-card data mover and system memory. It turns a list of memory buffers into a stream of address/length segments. In single-buffer mode it sends one segment, taken straight from its registers. In chained mode it starts with a first descriptor that software wrote into its registers. It then reads each later descriptor from an in-memory table. A descriptor is three 32-bit words: a link word, a buffer start address and a buffer byte count. The link word carries a byte offset from the table start, plus flag bits that say whether the walk continues and whether the count is replaced.

Before a segment leaves, its address and length are checked against the alignment rules. A violation sets a sticky error and stops the walk without emitting that segment. When the final segment has been accepted, a one-cycle completion pulse follows. Writing the control register with its enable bit clear stops the engine at once, from any state.

Both data interfaces use valid/ready. A segment offer on `seg_*` holds its fields steady until `seg_ready` is seen high on a clock edge. A descriptor word request on `mem_req_*` holds its address until `mem_req_ready` is seen high. The memory returns exactly one `mem_rsp_valid` word per accepted request, in order, and the block always accepts it. Only one request is outstanding at a time.

Top module: `sgdma_chain`

## Requirements
- R1: After reset, `seg_valid`, `mem_req_valid`, `busy`, `err_flag` and `xfer_done` are all low.
- R2: A control write (`cfg_addr`=0) with bit 0 set and bit 1 clear starts single-buffer mode. The engine emits exactly one segment, with the start-address register (`cfg_addr`=3) as address and the count register (`cfg_addr`=4) as length, and `seg_last` set. It issues no memory request, whatever the link register holds.
- R3: A control write with bits 0 and 1 both set starts chained mode. The first segment comes from the registers. Each later descriptor is fetched as three reads at T+O, T+O+4 and T+O+8, in the order link, address, count. T is the table start register (`cfg_addr`=1) and O is the link-word offset held in bits [15:0]. The link register is at `cfg_addr`=2.
- R4: The walk continues while the current link word has bit 31 set. The descriptor whose link word has bit 31 clear is the last one; its segment carries `seg_last`, and no further reads follow. Bit 29 of a link word has no effect.
- R5: When bit 30 of the link word that points to a descriptor is set, the fetched count becomes that descriptor's length. When bit 30 is clear, the previous length is kept and the fetched count word is ignored.
- R6: Every segment needs an address with bits [1:0] zero. Every segment except the last also needs a length that is a multiple of BURST_BYTES.
- R7: A segment that breaks R6 is not emitted. `err_flag` is set, and the engine returns to idle without a completion pulse. `err_flag` stays set until the next control write.
- R8: `xfer_done` is high for exactly one cycle, in the cycle after the last segment's handshake, and at no other time.
- R9: A control write with bit 0 clear sends the engine to idle on that clock edge. From the next cycle `seg_valid`, `mem_req_valid` and `busy` are low, and no completion pulse follows.
- R10: An offered segment or memory request holds valid high, with stable fields, until it is accepted or the engine is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control, 1 table start, 2 link, 3 address, 4 count |
| cfg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Data mover accepts the segment |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| seg_last | output | 1 | Final segment of the transfer |
| busy | output | 1 | Engine not idle |
| err_flag | output | 1 | Sticky alignment error |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with BURST_BYTES=8 and LEN_W=16. The small burst makes lengths that are a multiple of the burst easy to tell apart from those that are not (0x44 fails, 0x40 passes). It also lets a three-descriptor chain fit in a 64-word memory model at table start zero. The default 32-bit address width is kept, so the offset adder and the start-address path are exercised at full width. Stalling the memory request port and the segment port separately brings the hold rules and a stop during a pending fetch within reach.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int unsigned LNK_MORE_BIT = 31;
  localparam int unsigned LNK_NEWLEN_BIT = 30;

  localparam int unsigned CTL_RUN_BIT = 0;
  localparam int unsigned CTL_CHAIN_BIT = 1;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_TABLE = 3'd1,
    SEL_LINK  = 3'd2,
    SEL_ADDR  = 3'd3,
    SEL_COUNT = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_CHECK,
    WK_OFFER,
    WK_ASK,
    WK_WAIT
  } walk_state_e;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 24,
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             err_set,
  output logic             go,
  output logic             go_chain,
  output logic             halt,
  output logic [AW-1:0]    tbl_base,
  output logic             lnk_more,
  output logic             lnk_newlen,
  output logic [OFS_W-1:0] lnk_ofs,
  output logic [AW-1:0]    buf_addr,
  output logic [LEN_W-1:0] buf_len,
  output logic             err_flag
);

  logic ctl_wr;

  assign ctl_wr   = cfg_we && (cfg_addr == SEL_CTRL);
  assign go       = ctl_wr && cfg_wdata[CTL_RUN_BIT];
  assign go_chain = cfg_wdata[CTL_CHAIN_BIT];
  assign halt     = ctl_wr && !cfg_wdata[CTL_RUN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base   <= '0;
      lnk_more   <= 1'b0;
      lnk_newlen <= 1'b0;
      lnk_ofs    <= '0;
      buf_addr   <= '0;
      buf_len    <= '0;
      err_flag   <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          SEL_TABLE: tbl_base <= cfg_wdata[AW-1:0];
          SEL_LINK: begin
            lnk_more   <= cfg_wdata[LNK_MORE_BIT];
            lnk_newlen <= cfg_wdata[LNK_NEWLEN_BIT];
            lnk_ofs    <= cfg_wdata[OFS_W-1:0];
          end
          SEL_ADDR:  buf_addr <= cfg_wdata[AW-1:0];
          SEL_COUNT: buf_len  <= cfg_wdata[LEN_W-1:0];
          default: ;
        endcase
      end
      if (ctl_wr) err_flag <= 1'b0;
      else if (err_set) err_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/sgdma_seg_check.sv
module sgdma_seg_check #(
  parameter int unsigned AW          = 32,
  parameter int unsigned LEN_W       = 24,
  parameter int unsigned BURST_BYTES = 16
) (
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] len,
  input  logic             is_last,
  output logic             bad
);

  localparam int unsigned BLG = $clog2(BURST_BYTES);

  logic addr_bad;
  logic len_bad;

  assign addr_bad = (base[1:0] != 2'b00);

  generate
    if (BLG > 0) begin : g_len_rule
      assign len_bad = !is_last && (len[BLG-1:0] != '0);
    end else begin : g_no_len_rule
      assign len_bad = 1'b0;
    end
  endgenerate

  assign bad = addr_bad || len_bad;

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 24,
  parameter int unsigned OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_chain,
  input  logic             halt,
  input  logic [AW-1:0]    tbl_base,
  input  logic             lnk_more,
  input  logic             lnk_newlen,
  input  logic [OFS_W-1:0] lnk_ofs,
  input  logic [AW-1:0]    buf_addr,
  input  logic [LEN_W-1:0] buf_len,
  input  logic             seg_bad,
  output logic             err_set,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [AW-1:0]    seg_addr,
  output logic [LEN_W-1:0] seg_len,
  output logic             seg_last,
  output logic             busy,
  output logic             xfer_done
);

  walk_state_e        st;
  logic               chain_q;
  logic [AW-1:0]      tbl_q;
  logic               cur_more;
  logic               cur_newlen;
  logic [OFS_W-1:0]   cur_ofs;
  logic [AW-1:0]      cur_addr;
  logic [LEN_W-1:0]   cur_len;
  logic [1:0]         word_idx;
  logic [AW-1:0]      desc_ptr;
  logic               nx_more;
  logic               nx_newlen;
  logic [OFS_W-1:0]   nx_ofs;
  logic [AW-1:0]      nx_addr;
  logic               done_q;

  assign seg_last      = !chain_q || !cur_more;
  assign seg_addr      = cur_addr;
  assign seg_len       = cur_len;
  assign seg_valid     = (st == WK_OFFER);
  assign mem_req_valid = (st == WK_ASK);
  assign mem_req_addr  = desc_ptr + {{(AW-4){1'b0}}, word_idx, 2'b00};
  assign busy          = (st != WK_IDLE);
  assign err_set       = (st == WK_CHECK) && seg_bad && !halt;
  assign xfer_done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= WK_IDLE;
      chain_q    <= 1'b0;
      tbl_q      <= '0;
      cur_more   <= 1'b0;
      cur_newlen <= 1'b0;
      cur_ofs    <= '0;
      cur_addr   <= '0;
      cur_len    <= '0;
      word_idx   <= '0;
      desc_ptr   <= '0;
      nx_more    <= 1'b0;
      nx_newlen  <= 1'b0;
      nx_ofs     <= '0;
      nx_addr    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (halt) begin
        st <= WK_IDLE;
      end else begin
        case (st)
          WK_IDLE: begin
            if (go) begin
              chain_q    <= go_chain;
              tbl_q      <= tbl_base;
              cur_more   <= lnk_more;
              cur_newlen <= lnk_newlen;
              cur_ofs    <= lnk_ofs;
              cur_addr   <= buf_addr;
              cur_len    <= buf_len;
              st         <= WK_CHECK;
            end
          end
          WK_CHECK: begin
            st <= seg_bad ? WK_IDLE : WK_OFFER;
          end
          WK_OFFER: begin
            if (seg_ready) begin
              if (seg_last) begin
                done_q <= 1'b1;
                st     <= WK_IDLE;
              end else begin
                desc_ptr <= tbl_q + {{(AW-OFS_W){1'b0}}, cur_ofs};
                word_idx <= 2'd0;
                st       <= WK_ASK;
              end
            end
          end
          WK_ASK: begin
            if (mem_req_ready) st <= WK_WAIT;
          end
          WK_WAIT: begin
            if (mem_rsp_valid) begin
              case (word_idx)
                2'd0: begin
                  nx_more   <= mem_rsp_data[LNK_MORE_BIT];
                  nx_newlen <= mem_rsp_data[LNK_NEWLEN_BIT];
                  nx_ofs    <= mem_rsp_data[OFS_W-1:0];
                  word_idx  <= 2'd1;
                  st        <= WK_ASK;
                end
                2'd1: begin
                  nx_addr  <= mem_rsp_data[AW-1:0];
                  word_idx <= 2'd2;
                  st       <= WK_ASK;
                end
                default: begin
                  if (cur_newlen) cur_len <= mem_rsp_data[LEN_W-1:0];
                  cur_more   <= nx_more;
                  cur_newlen <= nx_newlen;
                  cur_ofs    <= nx_ofs;
                  cur_addr   <= nx_addr;
                  st         <= WK_CHECK;
                end
              endcase
            end
          end
          default: st <= WK_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sgdma_chain.sv
module sgdma_chain #(
  parameter int unsigned AW          = 32,
  parameter int unsigned LEN_W       = 24,
  parameter int unsigned OFS_W       = 16,
  parameter int unsigned BURST_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [AW-1:0]    seg_addr,
  output logic [LEN_W-1:0] seg_len,
  output logic             seg_last,
  output logic             busy,
  output logic             err_flag,
  output logic             xfer_done
);

  logic             go;
  logic             go_chain;
  logic             halt;
  logic [AW-1:0]    tbl_base;
  logic             lnk_more;
  logic             lnk_newlen;
  logic [OFS_W-1:0] lnk_ofs;
  logic [AW-1:0]    buf_addr;
  logic [LEN_W-1:0] buf_len;
  logic             seg_bad;
  logic             err_set;

  sgdma_regs #(.AW(AW), .LEN_W(LEN_W), .OFS_W(OFS_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .err_set(err_set),
    .go(go), .go_chain(go_chain), .halt(halt),
    .tbl_base(tbl_base),
    .lnk_more(lnk_more), .lnk_newlen(lnk_newlen), .lnk_ofs(lnk_ofs),
    .buf_addr(buf_addr), .buf_len(buf_len),
    .err_flag(err_flag)
  );

  sgdma_seg_check #(.AW(AW), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) check_i (
    .base(seg_addr), .len(seg_len), .is_last(seg_last), .bad(seg_bad)
  );

  sgdma_walker #(.AW(AW), .LEN_W(LEN_W), .OFS_W(OFS_W)) walk_i (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_chain(go_chain), .halt(halt),
    .tbl_base(tbl_base),
    .lnk_more(lnk_more), .lnk_newlen(lnk_newlen), .lnk_ofs(lnk_ofs),
    .buf_addr(buf_addr), .buf_len(buf_len),
    .seg_bad(seg_bad), .err_set(err_set),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .busy(busy), .xfer_done(xfer_done)
  );

endmodule

// File: rtl/sgdma_chain_chk.sv
module sgdma_chain_chk #(
  parameter int unsigned AW          = 32,
  parameter int unsigned LEN_W       = 24,
  parameter int unsigned BURST_BYTES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic             run_bit,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [AW-1:0]    seg_addr,
  input logic [LEN_W-1:0] seg_len,
  input logic             seg_last,
  input logic             busy,
  input logic             xfer_done
);

  logic stop_w;
  assign stop_w = cfg_we && (cfg_addr == 3'd0) && !run_bit;

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready && !stop_w) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last))); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !stop_w) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_SEG_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_addr[1:0] == 2'b00)); // R6
  AST_SEG_BURST_MULT: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_last) |-> ((seg_len & LEN_W'(BURST_BYTES - 1)) == '0)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(seg_valid && seg_ready && seg_last)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R8
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (!seg_valid && !mem_req_valid && !busy)); // R9
  AST_FETCH_XOR_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_valid && mem_req_valid)); // R3

endmodule

bind sgdma_chain sgdma_chain_chk #(.AW(AW), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .run_bit(cfg_wdata[0]),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
  .seg_last(seg_last), .busy(busy), .xfer_done(xfer_done)
);

// File: tb/sgdma_chain_tb_top.sv
module sgdma_chain_tb_top;

  localparam int unsigned AW = 32;
  localparam int unsigned LW = 16;
  localparam int unsigned BB = 8;
  localparam logic [31:0] F_MORE = 32'h8000_0000;
  localparam logic [31:0] F_NEWL = 32'h4000_0000;
  localparam logic [31:0] F_B29  = 32'h2000_0000;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic        last;
    logic        err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_1000, 16'h0040, 1'b0, 1'b0},
    '{32'h0000_1002, 16'h0040, 1'b0, 1'b1},
    '{32'h0000_1000, 16'h0044, 1'b0, 1'b1},
    '{32'h0000_1000, 16'h0043, 1'b1, 1'b0},
    '{32'h0000_1001, 16'h0040, 1'b1, 1'b1},
    '{32'h0000_2000, 16'h0008, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic seg_valid;
  logic seg_ready = 1'b1;
  logic [AW-1:0] seg_addr;
  logic [LW-1:0] seg_len;
  logic seg_last;
  logic busy;
  logic err_flag;
  logic xfer_done;

  logic [31:0] mem [0:63];
  logic [31:0] log_addr [0:31];
  logic [LW-1:0] log_len [0:31];
  logic log_last [0:31];
  int seg_n = 0;
  logic [31:0] req_log [0:31];
  int req_n = 0;
  int done_n = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sgdma_chain #(.AW(AW), .LEN_W(LW), .OFS_W(16), .BURST_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_last(seg_last), .busy(busy), .err_flag(err_flag), .xfer_done(xfer_done)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= mem[mem_req_addr[7:2]];
      if (mem_req_valid && mem_req_ready) begin
        req_log[req_n[4:0]] <= mem_req_addr;
        req_n <= req_n + 1;
      end
      if (seg_valid && seg_ready) begin
        log_addr[seg_n[4:0]] <= seg_addr;
        log_len[seg_n[4:0]]  <= seg_len;
        log_last[seg_n[4:0]] <= seg_last;
        seg_n <= seg_n + 1;
      end
      if (xfer_done) done_n <= done_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic put_desc(input int w, input logic [31:0] l, input logic [31:0] b, input logic [31:0] s);
    mem[w] = l; mem[w+1] = b; mem[w+2] = s;
  endtask

  task automatic first_desc(input logic [31:0] l, input logic [31:0] b, input logic [31:0] s);
    wr(3'd1, 32'h0);
    wr(3'd2, l);
    wr(3'd3, b);
    wr(3'd4, s);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0, r0, d0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!seg_valid && !mem_req_valid && !busy && !err_flag && !xfer_done, "R1 idle outputs in reset",
          {27'd0, seg_valid, mem_req_valid, busy, err_flag, xfer_done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!seg_valid && !mem_req_valid && !busy && !err_flag && !xfer_done, "R1 idle after reset",
          {27'd0, seg_valid, mem_req_valid, busy, err_flag, xfer_done}, 32'h0);

    // R6 R7: alignment vectors
    put_desc(3, 32'h0, 32'h0000_3000, 32'h10);
    foreach (VECS[k]) begin
      s0 = seg_n;
      first_desc(F_MORE | F_NEWL | 32'd12, VECS[k].base, {16'h0, VECS[k].len});
      wr(3'd0, VECS[k].last ? 32'h1 : 32'h3);
      settle();
      check(err_flag == VECS[k].err, "R7 error flag per vector", {31'd0, err_flag}, {31'd0, VECS[k].err});
      if (VECS[k].err) begin
        check(seg_n == s0, "R7 no segment on violation", seg_n, s0);
      end else begin
        check(log_addr[s0[4:0]] == VECS[k].base && log_len[s0[4:0]] == VECS[k].len,
              "R6 aligned segment passes", log_addr[s0[4:0]], VECS[k].base);
      end
    end

    // R2: single mode ignores link and memory
    s0 = seg_n; r0 = req_n; d0 = done_n;
    first_desc(F_MORE | F_NEWL | 32'd12, 32'h0000_5004, 32'h13);
    wr(3'd0, 32'h1);
    settle();
    check(seg_n == s0 + 1, "R2 one segment", seg_n - s0, 1);
    check(log_addr[s0[4:0]] == 32'h5004 && log_len[s0[4:0]] == 16'h13 && log_last[s0[4:0]],
          "R2 segment fields", log_addr[s0[4:0]], 32'h5004);
    check(req_n == r0, "R2 no memory reads", req_n - r0, 0);
    check(done_n == d0 + 1, "R8 one done pulse single", done_n - d0, 1);

    // R3 R4 R5: three-entry chain
    put_desc(3, F_MORE | 32'd24, 32'h0000_2000, 32'h30);
    put_desc(6, F_NEWL | F_B29 | 32'd36, 32'h0000_3000, 32'h77);
    s0 = seg_n; r0 = req_n; d0 = done_n;
    first_desc(F_MORE | F_NEWL | 32'd12, 32'h0000_1000, 32'h20);
    wr(3'd0, 32'h3);
    settle();
    check(seg_n == s0 + 3, "R4 chain length", seg_n - s0, 3);
    check(log_addr[(s0+1)%32] == 32'h2000 && log_len[(s0+1)%32] == 16'h30, "R5 size loaded when flag set",
          {16'h0, log_len[(s0+1)%32]}, 32'h30);
    check(log_addr[(s0+2)%32] == 32'h3000 && log_len[(s0+2)%32] == 16'h30, "R5 size kept when flag clear",
          {16'h0, log_len[(s0+2)%32]}, 32'h30);
    check(!log_last[s0%32] && !log_last[(s0+1)%32] && log_last[(s0+2)%32], "R4 last only on end entry",
          {29'd0, log_last[s0%32], log_last[(s0+1)%32], log_last[(s0+2)%32]}, 32'h1);
    check(req_n == r0 + 6, "R3 six descriptor reads", req_n - r0, 6);
    for (int j = 0; j < 6; j++)
      check(req_log[(r0+j)%32] == 32'd12 + 32'(4*j), "R3 read order", req_log[(r0+j)%32], 32'd12 + 32'(4*j));
    check(done_n == d0 + 1, "R8 one done pulse chain", done_n - d0, 1);

    // R10 R8: segment back-pressure
    s0 = seg_n; d0 = done_n;
    seg_ready = 1'b0;
    first_desc(32'h0, 32'h0000_4000, 32'h11);
    wr(3'd0, 32'h1);
    repeat (6) @(negedge clk);
    check(seg_valid && seg_addr == 32'h4000 && seg_len == 16'h11, "R10 segment held", seg_addr, 32'h4000);
    check(done_n == d0, "R8 no done before handshake", done_n - d0, 0);
    seg_ready = 1'b1;
    settle();
    check(seg_n == s0 + 1 && done_n == d0 + 1, "R8 done after release", done_n - d0, 1);

    // R10 R9: stalled fetch then stop
    s0 = seg_n; d0 = done_n;
    mem_req_ready = 1'b0;
    first_desc(F_MORE | F_NEWL | 32'd12, 32'h0000_1000, 32'h20);
    wr(3'd0, 32'h3);
    repeat (6) @(negedge clk);
    check(mem_req_valid && mem_req_addr == 32'd12, "R10 request held", mem_req_addr, 32'd12);
    wr(3'd0, 32'h0);
    check(!busy && !mem_req_valid && !seg_valid, "R9 stopped", {29'd0, busy, mem_req_valid, seg_valid}, 32'h0);
    mem_req_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(done_n == d0 && !busy, "R9 no done after stop", done_n - d0, 0);

    // R7: error on a fetched descriptor, sticky until control write
    put_desc(3, 32'h0, 32'h0000_2001, 32'h4);
    s0 = seg_n; d0 = done_n;
    first_desc(F_MORE | F_NEWL | 32'd12, 32'h0000_1000, 32'h20);
    wr(3'd0, 32'h3);
    settle();
    check(seg_n == s0 + 1 && err_flag && !busy, "R7 mid-chain violation", seg_n - s0, 1);
    check(done_n == d0, "R7 no done on error", done_n - d0, 0);
    repeat (5) @(negedge clk);
    check(err_flag, "R7 flag sticky", {31'd0, err_flag}, 32'h1);
    wr(3'd0, 32'h0);
    check(!err_flag, "R7 cleared by control write", {31'd0, err_flag}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule